// File: doc/BRIEF.md
# 1-Wire Master Slot Generator

This block is the timing engine on the master side of a single open-drain 1-Wire line. On command it produces one of four line primitives: a reset followed by a presence check, a write-0 slot, a write-1 slot, or a read slot. It never drives the line high. It asserts an output-enable that an external open-drain pad turns into a low. It watches the line through a two-flop synchronizer.

A host selects the primitive with `cmd`, supplies `wr_bit` for writes, and pulses `start` while `busy` is low. Timing comes from a microsecond tick divided from the system clock. The microsecond counter is restarted whenever a timed phase begins, so every phase lasts an exact whole number of microseconds. Byte assembly, ROM commands and CRC checking belong to the layer above.

Command encoding on `cmd`:
- 2'b00: reset with presence check.
- 2'b01: write slot, with `wr_bit` selecting the write-1 or write-0 shape.
- 2'b10: read slot.
- 2'b11: unused.

The controller has seven states:
- IDLE: waits. An accepted `start` moves it to RST_LOW for a reset, or to SLOT_LOW for a read or write.
- RST_LOW: pulls the line low. When the reset-low time expires it goes to RST_LISTEN.
- RST_LISTEN: releases the line and samples presence part way through. When the listen window ends it goes to DONE.
- SLOT_LOW: pulls the line low. When the slot's low time expires it goes to SLOT_OPEN.
- SLOT_OPEN: releases the line and, for reads, samples the data bit. When the slot time ends it goes to RECOVER.
- RECOVER: holds the line released. When the recovery time ends it goes to DONE.
- DONE: pulses `done` and returns to IDLE on the next clock.

Top module: `onewire_slot_master`

## Requirements
- R1: After reset, `line_oe`, `busy`, `done`, `presence` and `rd_bit` are all 0.
- R2: A `start` in IDLE with `cmd`=2'b00 drives `line_oe` high for exactly RSTL_US microseconds. The line is then released for RSTH_US microseconds before `done`.
- R3: `presence` becomes 1 if the synchronized line is low PRES_US microseconds after the reset release, and 0 if it is high. Its value holds unchanged through later slots until the next reset command.
- R4: A write with `wr_bit`=1 (`cmd`=2'b01) drives `line_oe` high for exactly W1L_US microseconds from the start of the slot.
- R5: A write with `wr_bit`=0 (`cmd`=2'b01) drives `line_oe` high for exactly W0L_US microseconds from the start of the slot.
- R6: A read (`cmd`=2'b10) drives `line_oe` high for exactly RDL_US microseconds. `rd_bit` takes the synchronized line level RDS_US microseconds after the slot start, and is held until the next read.
- R7: Every read or write keeps `busy` high for (SLOT_US+REC_US) microseconds plus one clock, and a reset for (RSTL_US+RSTH_US) microseconds plus one clock. `done` pulses for exactly one clock in the last busy cycle with `line_oe` low.
- R8: A `start` that arrives while `busy` is high is ignored, including in the cycle where `done` is high. It changes neither the running primitive nor the cycles after it.
- R9: A `start` with `cmd`=2'b11 is ignored: `busy` and `line_oe` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd | input | 2 | Primitive select (00 reset, 01 write, 10 read, 11 unused) |
| start | input | 1 | One-clock request, accepted only when idle |
| wr_bit | input | 1 | Bit value for a write slot |
| line_in | input | 1 | Raw level of the 1-Wire line |
| line_oe | output | 1 | 1 pulls the line low through the open-drain pad |
| busy | output | 1 | High from the accepted start through the done cycle |
| done | output | 1 | One-clock completion pulse |
| rd_bit | output | 1 | Bit sampled by the last read slot |
| presence | output | 1 | Result of the last reset's presence check |

## Verification
Two functions share one cycle when a new request lands on the `done` cycle. In that cycle the completion pulse and request acceptance coincide, and the controller is still busy. The bench raises `start` exactly on the cycle it sees `done`, and separately during the middle of a read slot. It judges both cases by the unchanged low time, the unchanged busy length and the sampled bit of the running slot, and by `busy` staying low for the following cycles. A second coincidence is a slave level change near a sample point. This is kept well away from the sample instants, so the expected bit is unambiguous.

// File: rtl/onewire_pkg.sv
`timescale 1ns/1ps
package onewire_pkg;

    typedef enum logic [1:0] {
        OW_CMD_RESET = 2'b00,
        OW_CMD_WRITE = 2'b01,
        OW_CMD_READ  = 2'b10,
        OW_CMD_NONE  = 2'b11
    } ow_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_RST_LISTEN,
        ST_SLOT_LOW,
        ST_SLOT_OPEN,
        ST_RECOVER,
        ST_DONE
    } ow_state_e;

endpackage

// File: rtl/ow_line_sync.sv
`timescale 1ns/1ps
module ow_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] ff;

    // idle level of an open-drain line is high
    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff[i] <= 1'b1;
                    else        ff[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) ff[i] <= 1'b1;
                    else        ff[i] <= ff[i-1];
                end
            end
        end
    endgenerate

    assign q = ff[STAGES-1];
endmodule

// File: rtl/ow_us_timer.sv
`timescale 1ns/1ps
module ow_us_timer #(
    parameter int CLKS_PER_US = 200,
    parameter int CNT_W       = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic             tick,
    output logic [CNT_W-1:0] us_cnt
);
    localparam int PRE_W = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_US - 1);

    logic [PRE_W-1:0] pre;

    assign tick = (pre == PRE_LAST);

    // clr restarts both the prescaler and the microsecond count so that
    // a phase begun on a clear lasts a whole number of microseconds
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre    <= '0;
            us_cnt <= '0;
        end else if (clr) begin
            pre    <= '0;
            us_cnt <= '0;
        end else if (tick) begin
            pre    <= '0;
            us_cnt <= us_cnt + 1'b1;
        end else begin
            pre    <= pre + 1'b1;
        end
    end
endmodule

// File: rtl/onewire_slot_master.sv
`timescale 1ns/1ps
module onewire_slot_master
    import onewire_pkg::*;
#(
    parameter int CLKS_PER_US = 200,
    parameter int SYNC_STAGES = 2,
    parameter int RSTL_US     = 480,
    parameter int RSTH_US     = 480,
    parameter int PRES_US     = 70,
    parameter int SLOT_US     = 65,
    parameter int W1L_US      = 6,
    parameter int W0L_US      = 60,
    parameter int RDL_US      = 1,
    parameter int RDS_US      = 13,
    parameter int REC_US      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd,
    input  logic       start,
    input  logic       wr_bit,
    input  logic       line_in,
    output logic       line_oe,
    output logic       busy,
    output logic       done,
    output logic       rd_bit,
    output logic       presence
);
    localparam int MAX_A  = (RSTL_US > RSTH_US) ? RSTL_US : RSTH_US;
    localparam int MAX_B  = (SLOT_US > REC_US) ? SLOT_US : REC_US;
    localparam int MAX_US = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_US + 2);

    ow_state_e        st, st_nxt;
    ow_cmd_e          op_q;
    logic             wr_q;
    logic             line_s;
    logic             tick;
    logic [CNT_W-1:0] us_cnt;
    logic             tmr_clr;
    logic             smp_pres;
    logic             smp_rd;
    int unsigned      low_us;

    ow_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (line_s)
    );

    ow_us_timer #(.CLKS_PER_US(CLKS_PER_US), .CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tmr_clr),
        .tick   (tick),
        .us_cnt (us_cnt)
    );

    // true on the cycle whose edge completes microsecond t of the phase
    function automatic logic hit(input int unsigned t);
        return tick && (32'(us_cnt) == t - 1);
    endfunction

    always_comb begin
        if (op_q == OW_CMD_READ) low_us = RDL_US;
        else if (wr_q)           low_us = W1L_US;
        else                     low_us = W0L_US;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // next state and phase events
    always_comb begin
        st_nxt   = st;
        tmr_clr  = 1'b0;
        smp_pres = 1'b0;
        smp_rd   = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start && ow_cmd_e'(cmd) != OW_CMD_NONE) begin
                    tmr_clr = 1'b1;
                    st_nxt  = (ow_cmd_e'(cmd) == OW_CMD_RESET) ? ST_RST_LOW : ST_SLOT_LOW;
                end
            end
            ST_RST_LOW: begin
                if (hit(RSTL_US)) begin
                    tmr_clr = 1'b1;
                    st_nxt  = ST_RST_LISTEN;
                end
            end
            ST_RST_LISTEN: begin
                if (hit(PRES_US)) smp_pres = 1'b1;
                if (hit(RSTH_US)) st_nxt = ST_DONE;
            end
            ST_SLOT_LOW: begin
                if (op_q == OW_CMD_READ && hit(RDS_US)) smp_rd = 1'b1;
                if (hit(low_us)) st_nxt = ST_SLOT_OPEN;
            end
            ST_SLOT_OPEN: begin
                if (op_q == OW_CMD_READ && hit(RDS_US)) smp_rd = 1'b1;
                if (hit(SLOT_US)) begin
                    tmr_clr = 1'b1;
                    st_nxt  = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                if (hit(REC_US)) st_nxt = ST_DONE;
            end
            ST_DONE: begin
                st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        line_oe = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (st)
            ST_IDLE:       busy    = 1'b0;
            ST_RST_LOW:    line_oe = 1'b1;
            ST_SLOT_LOW:   line_oe = 1'b1;
            ST_DONE:       done    = 1'b1;
            ST_RST_LISTEN,
            ST_SLOT_OPEN,
            ST_RECOVER:    line_oe = 1'b0;
            default:       busy    = 1'b0;
        endcase
    end

    // command capture and sampled results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= OW_CMD_RESET;
            wr_q     <= 1'b0;
            presence <= 1'b0;
            rd_bit   <= 1'b0;
        end else begin
            if (st == ST_IDLE && start) begin
                op_q <= ow_cmd_e'(cmd);
                wr_q <= wr_bit;
            end
            if (smp_pres) presence <= ~line_s;
            if (smp_rd)   rd_bit   <= line_s;
        end
    end
endmodule

// File: rtl/ow_slot_checker.sv
`timescale 1ns/1ps
module ow_slot_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cmd,
    input logic       start,
    input logic       line_oe,
    input logic       busy,
    input logic       done,
    input logic       rd_bit,
    input logic       presence
);
    // the line is pulled only inside an operation (R2)
    p_oe_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_oe |-> busy);

    // results change only while an operation runs (R3)
    p_result_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(presence) && $stable(rd_bit)));

    // done lies in the final busy cycle (R7)
    p_done_in_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !line_oe));

    // done is one clock and busy ends after it (R7)
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // an operation begins only from a request (R8)
    p_busy_from_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // unused command code leaves the block idle (R9)
    p_unused_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cmd == 2'b11) |=> (!busy && !line_oe));
endmodule

bind onewire_slot_master ow_slot_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .start    (start),
    .line_oe  (line_oe),
    .busy     (busy),
    .done     (done),
    .rd_bit   (rd_bit),
    .presence (presence)
);

// File: tb/onewire_slot_master_tb_top.sv
`timescale 1ns/1ps
module onewire_slot_master_tb_top;
    localparam int N     = 4;
    localparam int RSTL  = 480;
    localparam int RSTH  = 480;
    localparam int PRES  = 70;
    localparam int SLOT  = 65;
    localparam int W1L   = 6;
    localparam int W0L   = 60;
    localparam int RDL   = 1;
    localparam int RDS   = 13;
    localparam int REC   = 5;

    // {cmd[1:0], wr_bit, slave_mode[1:0], expected flag}
    // slave_mode: 0 none, 1 holds low 30 us from slot start, 2 presence pulse
    localparam int NVEC = 8;
    localparam logic [5:0] VEC [NVEC] = '{
        {2'b00, 1'b0, 2'd2, 1'b1},   // reset, device answers
        {2'b01, 1'b1, 2'd0, 1'b0},   // write 1
        {2'b10, 1'b0, 2'd1, 1'b0},   // read, slave sends 0
        {2'b01, 1'b0, 2'd0, 1'b0},   // write 0
        {2'b10, 1'b0, 2'd0, 1'b1},   // read, slave sends 1
        {2'b00, 1'b0, 2'd0, 1'b0},   // reset, nobody answers
        {2'b10, 1'b0, 2'd0, 1'b1},   // read 1
        {2'b01, 1'b1, 2'd0, 1'b0}    // write 1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd = 2'b00;
    logic       start = 1'b0;
    logic       wr_bit = 1'b0;
    logic       slave_low = 1'b0;
    logic       line_in;
    logic       line_oe, busy, done, rd_bit, presence;
    int         checks = 0;
    int         fails  = 0;

    always #2.5 clk = ~clk;

    assign line_in = ~(line_oe | slave_low);

    onewire_slot_master #(.CLKS_PER_US(N)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .start    (start),
        .wr_bit   (wr_bit),
        .line_in  (line_in),
        .line_oe  (line_oe),
        .busy     (busy),
        .done     (done),
        .rd_bit   (rd_bit),
        .presence (presence)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] c, input logic w, input int smode,
                          input int inj_at, input bit inj_done,
                          output int oe_clks, output int busy_clks, output int done_cnt);
        oe_clks = 0; busy_clks = 0; done_cnt = 0;
        @(negedge clk);
        cmd = c; wr_bit = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            begin
                while (busy) begin
                    busy_clks++;
                    if (line_oe) oe_clks++;
                    if (done) begin
                        done_cnt++;
                        if (inj_done) begin cmd = 2'b00; start = 1'b1; end
                    end else if (busy_clks == inj_at) begin
                        cmd = 2'b00; start = 1'b1;
                    end else begin
                        start = 1'b0;
                    end
                    @(negedge clk);
                end
                start = 1'b0;
            end
            begin
                if (smode == 1) begin
                    slave_low = 1'b1;
                    repeat (30*N) @(negedge clk);
                    slave_low = 1'b0;
                end else if (smode == 2) begin
                    repeat ((RSTL+20)*N) @(negedge clk);
                    slave_low = 1'b1;
                    repeat (100*N) @(negedge clk);
                    slave_low = 1'b0;
                end
            end
        join
    endtask

    task automatic idle_watch(input string req);
        int hits = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (busy || line_oe) hits++;
        end
        check(hits == 0, req, hits, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int oe_c, busy_c, done_c, exp_low, exp_busy;
        logic pres_exp;
        logic [1:0] c;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(line_oe == 0 && busy == 0 && done == 0, "R1 ctrl", {line_oe, busy, done}, 0);
        check(presence == 0 && rd_bit == 0, "R1 result", {presence, rd_bit}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(busy == 0 && line_oe == 0, "R1 after release", {busy, line_oe}, 0);

        pres_exp = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            c = VEC[i][5:4];
            run_op(c, VEC[i][3], int'(VEC[i][2:1]), -1, 1'b0, oe_c, busy_c, done_c);
            if (c == 2'b00) begin
                exp_low  = RSTL*N;
                exp_busy = (RSTL+RSTH)*N + 1;
                pres_exp = VEC[i][0];
                check(oe_c == exp_low, "R2 reset low", oe_c, exp_low);
            end else begin
                exp_busy = (SLOT+REC)*N + 1;
                if (c == 2'b10) begin
                    exp_low = RDL*N;
                    check(oe_c == exp_low, "R6 read low", oe_c, exp_low);
                    check(rd_bit == VEC[i][0], "R6 read bit", rd_bit, VEC[i][0]);
                end else if (VEC[i][3]) begin
                    exp_low = W1L*N;
                    check(oe_c == exp_low, "R4 write1 low", oe_c, exp_low);
                end else begin
                    exp_low = W0L*N;
                    check(oe_c == exp_low, "R5 write0 low", oe_c, exp_low);
                end
            end
            check(busy_c == exp_busy, "R7 busy length", busy_c, exp_busy);
            check(done_c == 1, "R7 done pulse", done_c, 1);
            check(presence == pres_exp, "R3 presence", presence, pres_exp);
        end

        // R8: request in the middle of a read slot
        run_op(2'b10, 1'b0, 1, 20, 1'b0, oe_c, busy_c, done_c);
        check(oe_c == RDL*N, "R8 mid low", oe_c, RDL*N);
        check(busy_c == (SLOT+REC)*N + 1, "R8 mid busy", busy_c, (SLOT+REC)*N + 1);
        check(rd_bit == 1'b0, "R8 mid read bit", rd_bit, 0);
        idle_watch("R8 mid after");

        // R8: request on the done cycle
        run_op(2'b01, 1'b0, 0, -1, 1'b1, oe_c, busy_c, done_c);
        check(oe_c == W0L*N, "R8 done low", oe_c, W0L*N);
        check(busy_c == (SLOT+REC)*N + 1, "R8 done busy", busy_c, (SLOT+REC)*N + 1);
        idle_watch("R8 done after");
        check(presence == pres_exp, "R3 hold", presence, pres_exp);

        // R9: unused command code
        @(negedge clk);
        cmd = 2'b11; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 0 && line_oe == 0, "R9 immediate", {busy, line_oe}, 0);
        idle_watch("R9 later");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule